// File: doc/BRIEF.md
# SRAM Supply Rail Handover Controller

This block decides which of two power rails feeds a group of on-chip SRAM arrays: the core rail or the memory-domain rail. Software asks for a rail by writing a mode register. The block then moves the arrays over in four timed phases. First it freezes the array clock. Next it flips the rail select. Then it lets the clock run again. Last, it waits a settling interval before it reports that the switch is done. Each phase takes its length from its own byte of a 32-bit delay register.

Software polls a 5-bit status field. It treats the switch as finished only when the status equals the done code of the rail it asked for. Every other code means the handover is still running. A rail request that arrives in the middle of a handover is held, and the block serves it once the current handover has finished. A request for the rail that is already selected changes nothing. The analog head switches are represented only by the `rail_sel` output.

Top module: `sram_rail_mux`

## Requirements
- R1: After reset, `rail_sel` is 0 (memory-domain rail), `clk_halt` is 0, status reads 0x00, the delay register reads 0 and the mode register reads 0x00.
- R2: In the low byte of a write to address 0, the value 0x00 requests the memory-domain rail (`rail_sel`=0) and 0x02 requests the core rail (`rail_sel`=1). Any other value is ignored: it leaves the mode readback, the outputs and any held request unchanged.
- R3: Status is 0x00 when the block is idle on the memory-domain rail and 0x03 when it is idle on the core rail. During a handover the status is 0x10 (clock halted), 0x11 (select flipped), 0x12 (clock resuming) or 0x13 (settling).
- R4: Address 1 is the delay register. Bits 7:0 hold the select delay, 15:8 the resume delay, 23:16 the halt delay and 31:24 the settle delay. A write replaces the whole word, which is what lets software update one field by read-modify-write. The register changes only when it is written. Address 2 reads the status in bits 4:0. Any other read address returns 0.
- R5: `clk_halt` is high during the halt phase and the select phase, and low at every other time.
- R6: Each phase lasts its delay field plus one cycles. A handover therefore lasts the sum of the four fields plus four cycles, counted from the clock edge that accepts the mode write.
- R7: `rail_sel` changes only on entry to the select phase, and `clk_halt` has been high for at least one cycle before that edge.
- R8: A valid mode write made while a handover runs is held. If several arrive, the last one wins. After the handover ends, the done code shows for one cycle, and then the held request starts a new handover if it differs from the current rail.
- R9: A valid mode write that names the rail already selected, made while the block is idle, leaves `clk_halt` low and leaves the status at the current done code.
- R10: A phase counter loads its delay field when the phase is entered. A write to the delay register during a phase changes only the phases that begin after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 mode, 1 delay) |
| wr_data | input | 4*FIELD_W | Write data |
| rd_addr | input | ADDR_W | Read address (0 mode, 1 delay, 2 status) |
| rd_data | output | 4*FIELD_W | Combinational read data |
| rail_sel | output | 1 | 0 = memory-domain rail, 1 = core rail |
| clk_halt | output | 1 | Holds the array clock stopped |
| status | output | STAT_W | Done or phase code |

## Verification
Two events can land in the same cycle. The first case is a mode write that arrives on the edge where the settle phase ends. That write must still be held and served after the one-cycle done window, not lost. The bench provokes this case with writes made during running handovers, including a write that reverses the current request and a write that cancels a pending one. The second case is a delay-register write made while a phase is counting. The bench rewrites the delay word during the halt phase and checks that only the later phases pick up the new values. A behavioural reference model, compared on every clock, judges both cases, and directed checks confirm the exact cycle on which the done code appears.

// File: rtl/sram_rail_mux.sv
`timescale 1ns/1ps
module sram_rail_mux #(
  parameter int ADDR_W  = 2,
  parameter int FIELD_W = 8,
  parameter int STAT_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [4*FIELD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [4*FIELD_W-1:0] rd_data,
  output logic                 rail_sel,
  output logic                 clk_halt,
  output logic [STAT_W-1:0]    status
);
  localparam int DW = 4*FIELD_W;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DLY  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [7:0] M_MEM  = 8'h00;
  localparam logic [7:0] M_CORE = 8'h02;
  localparam logic [STAT_W-1:0] ST_MEM    = STAT_W'(5'h00);
  localparam logic [STAT_W-1:0] ST_CORE   = STAT_W'(5'h03);
  localparam logic [STAT_W-1:0] ST_HALT   = STAT_W'(5'h10);
  localparam logic [STAT_W-1:0] ST_SWAP   = STAT_W'(5'h11);
  localparam logic [STAT_W-1:0] ST_RESUME = STAT_W'(5'h12);
  localparam logic [STAT_W-1:0] ST_SETTLE = STAT_W'(5'h13);

  typedef enum logic [2:0] {S_IDLE, S_HALT, S_SWAP, S_RESUME, S_SETTLE} st_t;

  st_t                st;
  logic [FIELD_W-1:0] cnt;
  logic [DW-1:0]      dly_q;
  logic [7:0]         mode_q;
  logic               tgt, pend, pend_tgt;
  logic               mode_wr, req_core, go_req, start;
  logic [FIELD_W-1:0] d_sel, d_res, d_halt, d_post;

  assign mode_wr  = wr_en && (wr_addr == A_MODE) &&
                    (wr_data[7:0] == M_MEM || wr_data[7:0] == M_CORE);
  assign req_core = (wr_data[7:0] == M_CORE);
  assign go_req   = mode_wr ? req_core : pend_tgt;
  assign start    = (st == S_IDLE) && (mode_wr || pend) && (go_req != rail_sel);

  assign d_sel  = dly_q[0*FIELD_W +: FIELD_W];
  assign d_res  = dly_q[1*FIELD_W +: FIELD_W];
  assign d_halt = dly_q[2*FIELD_W +: FIELD_W];
  assign d_post = dly_q[3*FIELD_W +: FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      dly_q    <= '0;
      mode_q   <= M_MEM;
      tgt      <= 1'b0;
      pend     <= 1'b0;
      pend_tgt <= 1'b0;
      rail_sel <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_DLY) dly_q <= wr_data;
      if (mode_wr) mode_q <= wr_data[7:0];
      if (st == S_IDLE) begin
        pend <= 1'b0;
        if (start) begin
          st  <= S_HALT;
          cnt <= d_halt;
          tgt <= go_req;
        end
      end else begin
        if (mode_wr) begin
          pend     <= 1'b1;
          pend_tgt <= req_core;
        end
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          case (st)
            S_HALT: begin
              st       <= S_SWAP;
              rail_sel <= tgt;
              cnt      <= d_sel;
            end
            S_SWAP: begin
              st  <= S_RESUME;
              cnt <= d_res;
            end
            S_RESUME: begin
              st  <= S_SETTLE;
              cnt <= d_post;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign clk_halt = (st == S_HALT) || (st == S_SWAP);

  always_comb begin
    case (st)
      S_HALT:   status = ST_HALT;
      S_SWAP:   status = ST_SWAP;
      S_RESUME: status = ST_RESUME;
      S_SETTLE: status = ST_SETTLE;
      default:  status = rail_sel ? ST_CORE : ST_MEM;
    endcase
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = {{(DW-8){1'b0}}, mode_q};
      A_DLY:   rd_data = dly_q;
      A_STAT:  rd_data = {{(DW-STAT_W){1'b0}}, status};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sram_rail_mux_chk.sv
`timescale 1ns/1ps
module sram_rail_mux_chk #(
  parameter int ADDR_W  = 2,
  parameter int FIELD_W = 8,
  parameter int STAT_W  = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [4*FIELD_W-1:0] wr_data,
  input logic                 rail_sel,
  input logic                 clk_halt,
  input logic [STAT_W-1:0]    status,
  input logic [4*FIELD_W-1:0] dly
);
  logic same_rail_wr;
  assign same_rail_wr = wr_en && wr_addr == ADDR_W'(0) &&
                        wr_data[7:0] == (rail_sel ? 8'h02 : 8'h00) &&
                        status == (rail_sel ? STAT_W'(3) : STAT_W'(0));

  p_legal_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status == STAT_W'(5'h00) || status == STAT_W'(5'h03) ||
    status == STAT_W'(5'h10) || status == STAT_W'(5'h11) ||
    status == STAT_W'(5'h12) || status == STAT_W'(5'h13));

  p_flip_under_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rail_sel) |-> clk_halt && $past(clk_halt));

  p_core_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status == STAT_W'(5'h03) |-> rail_sel && !clk_halt);

  p_mem_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status == STAT_W'(5'h00) |-> !rail_sel && !clk_halt);

  p_halt_opens_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_halt) |-> status == STAT_W'(5'h10));

  p_same_rail_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    same_rail_wr |=> !clk_halt && $stable(rail_sel));

  p_delay_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_W'(1)) |=> $stable(dly));
endmodule

bind sram_rail_mux sram_rail_mux_chk #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rail_sel(rail_sel), .clk_halt(clk_halt), .status(status), .dly(dly_q)
);

// File: tb/test_sram_rail_mux.sv
`timescale 1ns/1ps
module test_sram_rail_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rail_sel, clk_halt;
  logic [4:0]  status;

  int checks = 0, errors = 0, cyc = 0;
  bit armed = 0;

  sram_rail_mux i_sram_rail_mux (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rail_sel(rail_sel),
    .clk_halt(clk_halt), .status(status)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int        m_ph, m_left;
  bit        m_rail, m_tgt, m_pend, m_ptgt, m_req, m_valid;
  logic [31:0] m_dly;
  logic [7:0]  m_mode;

  function automatic int fld(input logic [31:0] d, input int k);
    return int'(d[8*k +: 8]);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_rail = 0; m_tgt = 0; m_pend = 0; m_ptgt = 0;
      m_dly = '0; m_mode = 8'h00;
    end else begin
      m_valid = wr_en && wr_addr == 2'd0 && (wr_data[7:0] == 8'h00 || wr_data[7:0] == 8'h02);
      m_req   = (wr_data[7:0] == 8'h02);
      if (m_ph == 0) begin
        if (m_valid) begin
          m_mode = wr_data[7:0];
          m_pend = 0;
          if (m_req != m_rail) begin m_ph = 1; m_left = fld(m_dly, 2); m_tgt = m_req; end
        end else if (m_pend) begin
          m_pend = 0;
          if (m_ptgt != m_rail) begin m_ph = 1; m_left = fld(m_dly, 2); m_tgt = m_ptgt; end
        end
      end else begin
        if (m_valid) begin m_mode = wr_data[7:0]; m_pend = 1; m_ptgt = m_req; end
        if (m_left > 0) m_left--;
        else if (m_ph == 1) begin m_ph = 2; m_rail = m_tgt; m_left = fld(m_dly, 0); end
        else if (m_ph == 2) begin m_ph = 3; m_left = fld(m_dly, 1); end
        else if (m_ph == 3) begin m_ph = 4; m_left = fld(m_dly, 3); end
        else m_ph = 0;
      end
      if (wr_en && wr_addr == 2'd1) m_dly = wr_data;
      armed = 1;
    end
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog R6 actual=%0d cycles expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [31:0] m_rd;
  always @(negedge clk) begin
    if (armed && rst_n) begin
      chk("R7 rail_sel vs model", {31'b0, rail_sel}, {31'b0, m_rail});
      chk("R5 clk_halt vs model", {31'b0, clk_halt}, {31'b0, (m_ph == 1 || m_ph == 2)});
      chk("R3 status vs model", {27'b0, status},
          m_ph == 0 ? (m_rail ? 32'h3 : 32'h0) : 32'h0F + m_ph);
      case (rd_addr)
        2'd0: m_rd = {24'b0, m_mode};
        2'd1: m_rd = m_dly;
        2'd2: m_rd = m_ph == 0 ? (m_rail ? 32'h3 : 32'h0) : 32'h0F + m_ph;
        default: m_rd = '0;
      endcase
      chk("R4 rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_status(input logic [4:0] s, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (status !== s);
  endtask

  logic [31:0] v;
  int n;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset rail_sel", {31'b0, rail_sel}, 32'h0);
    chk("R1 reset clk_halt", {31'b0, clk_halt}, 32'h0);
    chk("R1 reset status", {27'b0, status}, 32'h0);
    rd(2'd1, v); chk("R1 reset delay reg", v, 32'h0);
    rd(2'd0, v); chk("R1 reset mode reg", v, 32'h0);

    wr(2'd1, 32'h0102_0304);
    rd(2'd1, v); chk("R4 delay readback", v, 32'h0102_0304);
    rd(2'd2, v);
    wr(2'd0, 32'h02);
    wait_status(5'h03, n);
    chk("R6 handover length sum+4", n, 32'd15);
    chk("R2 core rail selected", {31'b0, rail_sel}, 32'h1);

    rd(2'd1, v);
    v[23:16] = 8'h05;
    wr(2'd1, v);
    rd(2'd1, v); chk("R4 read-modify-write halt field", v, 32'h0105_0304);

    wr(2'd0, 32'h02);
    repeat (3) begin
      @(negedge clk);
      chk("R9 same rail no halt", {31'b0, clk_halt}, 32'h0);
      chk("R9 same rail status", {27'b0, status}, 32'h3);
    end

    wr(2'd0, 32'h01);
    @(negedge clk);
    chk("R2 bad mode no halt", {31'b0, clk_halt}, 32'h0);
    rd(2'd0, v); chk("R2 bad mode readback", v, 32'h02);

    wr(2'd0, 32'h00);
    wr(2'd0, 32'h02);
    wait_status(5'h00, n);
    @(negedge clk);
    chk("R8 held request starts after done", {27'b0, status}, 32'h10);
    wait_status(5'h03, n);

    wr(2'd0, 32'h00);
    wr(2'd0, 32'h02);
    wr(2'd0, 32'h00);
    wait_status(5'h00, n);
    repeat (3) begin
      @(negedge clk);
      chk("R8 last write wins cancels", {27'b0, status}, 32'h0);
    end

    wr(2'd1, 32'h0003_0000);
    wr(2'd0, 32'h02);
    wr(2'd1, 32'h0000_0000);
    wait_status(5'h03, n);
    chk("R10 delay sampled at phase entry", n, 32'd6);

    wr(2'd0, 32'h00);
    wait_status(5'h00, n);
    chk("R6 zero delays length", n, 32'd5);

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule